// File: doc/BRIEF.md
# Sector Burst Error Corrector

This block repairs a single correctable burst error in a 512-byte sector buffer that sits in local byte-addressable memory. After a read has finished, the disk controller supplies three values: the position of the burst as a 1-based bit number, an 11-bit error pattern, and the number of bytes in the sector that the transfer actually covered. A start pulse captures all three. The block then steps through the bytes that the burst touches. For each byte it reads the byte, XORs in the part of the pattern that lands in that byte, and writes the result back.

Each byte takes one read cycle followed by one write cycle. The walk stops in any of three ways: the pattern has run out, the next byte would lie past the end of the sector, or the next byte would lie past the end of the transfer. A one-cycle done pulse ends every request and carries a status code. An all-zero pattern, or a burst whose first byte cannot be reached, is reported at once and leaves memory untouched.

Top module: `ecc_burst_fix`

## Requirements
- R1: After reset, done_o, mem_rd_o and mem_we_o are all low.
- R2: The 1-based position P is decoded as I = P-1. The first byte touched is at offset I>>3, and the starting shift S is I & 7.
- R3: The byte at step k (k = 0, 1, 2) receives a mask equal to bits 8k+7..8k of the pattern shifted left by S. In other words, it gets (pattern << (S-8k)) when that shift is positive and (pattern >> (8k-S)) when it is negative, with only the low 8 bits kept.
- R4: Successive steps touch consecutive byte offsets. The walk continues only while S-8k > -11, so it touches 3 bytes when S is 6 or 7 and 2 bytes otherwise.
- R5: No byte at an offset of 512 or more is ever read or written.
- R6: No byte at an offset equal to or greater than the transfer length len_i is ever read or written.
- R7: Each byte is read in one cycle (mem_rd_o high) and written in the next (mem_we_o high, same address). The write data is the read data XOR the mask. done_o pulses for exactly one cycle, in the cycle after the last write.
- R8: A zero pattern gives status 1 (empty), with done_o one cycle after start and no memory access.
- R9: A position of 0, or a first byte at or beyond either bound, gives status 2 (out of range), with done_o one cycle after start and no memory access.
- R10: A request that wrote at least one byte ends with status 0 (corrected).
- R11: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures pos_i, pat_i and len_i |
| pos_i | input | 16 | 1-based bit position of the burst |
| pat_i | input | 11 | Burst error pattern |
| len_i | input | 16 | Number of transfer bytes within this sector |
| mem_addr_o | output | 9 | Buffer byte address |
| mem_rd_o | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata_i | input | 8 | Read data, one cycle after mem_rd_o |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Corrected byte to write |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 corrected, 1 empty pattern, 2 out of range; valid with done_o |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Shift values 5, 6 and 7.** These sit where the walk changes between two and three bytes. A wrong stop test either leaves the top pattern bits uncorrected or damages a neighbouring byte.
- **Bursts that start on byte 510 and byte 511.** A missing sector bound would write past the buffer.
- **Transfers that end one or two bytes after the burst starts.** A missing length check would alter data the transfer never delivered.
- **Zero patterns and unreachable positions, including position 0.** A design that got these wrong would access memory or report the wrong status.
- **A second start pulse in the middle of a walk.** If it were accepted, the walk would be corrupted.

After every run the bench compares the whole buffer against the original contents. A wrong mask alignment therefore shows up as a byte that was not restored.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  typedef enum logic [1:0] {
    ST_FIXED = 2'd0,
    ST_EMPTY = 2'd1,
    ST_RANGE = 2'd2
  } fix_status_e;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RD   = 2'd1,
    W_WR   = 2'd2
  } walk_state_e;

endpackage

// File: rtl/ecc_pos_decode.sv
module ecc_pos_decode #(
  parameter int POS_W = 16,
  localparam int OFF_W = POS_W - 3
) (
  input  logic [POS_W-1:0] pos_i,
  output logic [OFF_W-1:0] off_o,
  output logic [2:0]       shift_o,
  output logic             zero_o
);

  logic [POS_W-1:0] idx;

  // position is 1-based; convert to a bit index
  always_comb begin
    idx     = pos_i - POS_W'(1);
    off_o   = idx[POS_W-1:3];
    shift_o = idx[2:0];
    zero_o  = (pos_i == '0);
  end

endmodule

// File: rtl/ecc_mask_gen.sv
module ecc_mask_gen #(
  parameter int PAT_W  = 11,
  parameter int NBYTES = 3,
  parameter int KW     = 2,
  localparam int SPAN_W = NBYTES * 8
) (
  input  logic [PAT_W-1:0] pat_i,
  input  logic [2:0]       shift_i,
  input  logic [KW-1:0]    step_i,
  output logic [7:0]       mask_o
);

  logic [SPAN_W-1:0] span;
  logic [7:0]        lane [NBYTES];

  assign span = SPAN_W'(pat_i) << shift_i;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = span[8*g +: 8];
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (int'(step_i) == i) mask_o = lane[i];
    end
  end

endmodule

// File: rtl/ecc_walk_fsm.sv
module ecc_walk_fsm
  import ecc_fix_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int PAT_W      = 11,
  parameter int LEN_W      = 16,
  parameter int OFF_W      = 13,
  parameter int KW         = 2,
  localparam int AW = $clog2(SECT_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [2:0]       shift_i,
  input  logic             pos_zero_i,
  input  logic [7:0]       mask_i,
  input  logic [7:0]       rdata_i,
  output logic [PAT_W-1:0] pat_q_o,
  output logic [2:0]       shift_q_o,
  output logic [KW-1:0]    step_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_we_o,
  output logic [7:0]       mem_wdata_o,
  output logic             done_o,
  output logic [1:0]       status_o
);

  walk_state_e      state_q;
  logic [PAT_W-1:0] pat_q;
  logic [LEN_W-1:0] len_q;
  logic [OFF_W-1:0] off_q;
  logic [2:0]       shift_q;
  logic [KW-1:0]    step_q;
  logic             done_q;
  fix_status_e      status_q;
  logic             start_ok;
  logic             more;

  function automatic logic in_bounds(input logic [OFF_W-1:0] off,
                                     input logic [LEN_W-1:0] len);
    return (32'(off) < SECT_BYTES) && (32'(off) < 32'(len));
  endfunction

  // next step still holds pattern bits: shift - 8(k+1) > -PAT_W
  always_comb begin
    start_ok = !pos_zero_i && in_bounds(off_i, len_i);
    more = ((int'(step_q) + 1) * 8 <= int'(shift_q) + PAT_W - 1) &&
           in_bounds(off_q + OFF_W'(1), len_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= W_IDLE;
      pat_q    <= '0;
      len_q    <= '0;
      off_q    <= '0;
      shift_q  <= '0;
      step_q   <= '0;
      done_q   <= 1'b0;
      status_q <= ST_FIXED;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        W_IDLE: begin
          if (start_i) begin
            pat_q   <= pat_i;
            len_q   <= len_i;
            off_q   <= off_i;
            shift_q <= shift_i;
            step_q  <= '0;
            if (pat_i == '0) begin
              done_q   <= 1'b1;
              status_q <= ST_EMPTY;
            end else if (!start_ok) begin
              done_q   <= 1'b1;
              status_q <= ST_RANGE;
            end else begin
              state_q <= W_RD;
            end
          end
        end
        W_RD: state_q <= W_WR;
        W_WR: begin
          if (more) begin
            off_q   <= off_q + OFF_W'(1);
            step_q  <= step_q + KW'(1);
            state_q <= W_RD;
          end else begin
            state_q  <= W_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_FIXED;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign pat_q_o     = pat_q;
  assign shift_q_o   = shift_q;
  assign step_o      = step_q;
  assign mem_addr_o  = off_q[AW-1:0];
  assign mem_rd_o    = (state_q == W_RD);
  assign mem_we_o    = (state_q == W_WR);
  assign mem_wdata_o = rdata_i ^ mask_i;
  assign done_o      = done_q;
  assign status_o    = status_q;

endmodule

// File: rtl/ecc_burst_fix.sv
module ecc_burst_fix #(
  parameter int SECT_BYTES = 512,
  parameter int PAT_W      = 11,
  parameter int POS_W      = 16,
  parameter int LEN_W      = 16,
  localparam int AW     = $clog2(SECT_BYTES),
  localparam int OFF_W  = POS_W - 3,
  localparam int NBYTES = (PAT_W + 7 + 7) / 8,
  localparam int KW     = $clog2(NBYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             mem_we_o,
  output logic [7:0]       mem_wdata_o,
  output logic             done_o,
  output logic [1:0]       status_o
);

  logic [OFF_W-1:0] off;
  logic [2:0]       shift;
  logic             pos_zero;
  logic [PAT_W-1:0] pat_q;
  logic [2:0]       shift_q;
  logic [KW-1:0]    step;
  logic [7:0]       mask;

  ecc_pos_decode #(.POS_W(POS_W)) u_dec (
    .pos_i   (pos_i),
    .off_o   (off),
    .shift_o (shift),
    .zero_o  (pos_zero)
  );

  ecc_mask_gen #(.PAT_W(PAT_W), .NBYTES(NBYTES), .KW(KW)) u_mask (
    .pat_i   (pat_q),
    .shift_i (shift_q),
    .step_i  (step),
    .mask_o  (mask)
  );

  ecc_walk_fsm #(
    .SECT_BYTES (SECT_BYTES),
    .PAT_W      (PAT_W),
    .LEN_W      (LEN_W),
    .OFF_W      (OFF_W),
    .KW         (KW)
  ) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pat_i       (pat_i),
    .len_i       (len_i),
    .off_i       (off),
    .shift_i     (shift),
    .pos_zero_i  (pos_zero),
    .mask_i      (mask),
    .rdata_i     (mem_rdata_i),
    .pat_q_o     (pat_q),
    .shift_q_o   (shift_q),
    .step_o      (step),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .status_o    (status_o)
  );

endmodule

// File: rtl/ecc_burst_fix_chk.sv
module ecc_burst_fix_chk #(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_rd_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic [1:0]    status_o
);

  assert_rd_then_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (mem_we_o && mem_addr_o == $past(mem_addr_o)));

  assert_wr_needs_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_rd_o));

  assert_rd_we_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_we_o) == (status_o == 2'd0)));

  assert_status_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'd3));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  assert_idle_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_rd_o && !mem_we_o));

endmodule

bind ecc_burst_fix ecc_burst_fix_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_rd_o   (mem_rd_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .status_o   (status_o)
);

// File: tb/tb_ecc_burst_fix.sv
`timescale 1ns/1ps
module tb_ecc_burst_fix;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pos_i = '0;
  logic [10:0] pat_i = '0;
  logic [15:0] len_i = '0;
  logic [8:0]  mem_addr_o;
  logic        mem_rd_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_we_o;
  logic [7:0]  mem_wdata_o;
  logic        done_o;
  logic [1:0]  status_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem  [512];
  logic [7:0] gold [512];

  always #10 clk_i = ~clk_i;

  ecc_burst_fix dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pos_i       (pos_i),
    .pat_i       (pat_i),
    .len_i       (len_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .status_o    (status_o)
  );

  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input string req, input int pos, input int pat,
                          input int len, input int seed, input bit poke);
    int exp_addr[$];
    int exp_mask[$];
    int exp_st;
    int n;
    int bad;
    // behavioural model of the walk
    if (pat == 0) exp_st = 1;
    else if (pos == 0) exp_st = 2;
    else begin
      int i, bitp, byt;
      i = pos - 1;
      bitp = i % 8;
      byt = i / 8;
      if (byt >= 512 || byt >= len) exp_st = 2;
      else begin
        exp_st = 0;
        while (byt < 512 && byt < len && bitp > -11) begin
          exp_addr.push_back(byt);
          exp_mask.push_back(bitp >= 0 ? ((pat << bitp) & 255) : ((pat >> -bitp) & 255));
          byt++;
          bitp -= 8;
        end
      end
    end
    n = exp_addr.size();
    for (int a = 0; a < 512; a++) begin
      gold[a] = 8'((a * 37 + seed * 13 + 11) & 255);
      mem[a]  = gold[a];
    end
    foreach (exp_addr[j]) mem[exp_addr[j]] = gold[exp_addr[j]] ^ 8'(exp_mask[j]);

    @(negedge clk_i);
    pos_i = 16'(pos); pat_i = 11'(pat); len_i = 16'(len); start_i = 1'b1;
    for (int c = 1; c <= 2 * n + 2; c++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      chk(mem_rd_o == (c % 2 == 1 && c < 2 * n + 1), {req, " rd strobe"}, mem_rd_o, c);
      chk(mem_we_o == (c % 2 == 0 && c <= 2 * n), {req, " wr strobe"}, mem_we_o, c);
      if (c % 2 == 1 && c < 2 * n + 1)
        chk(int'(mem_addr_o) == exp_addr[(c - 1) / 2], {req, " rd addr"},
            mem_addr_o, exp_addr[(c - 1) / 2]);
      if (c % 2 == 0 && c <= 2 * n) begin
        chk(int'(mem_addr_o) == exp_addr[c / 2 - 1], {req, " wr addr"},
            mem_addr_o, exp_addr[c / 2 - 1]);
        chk(mem_wdata_o == gold[exp_addr[c / 2 - 1]], {req, " wr data"},
            mem_wdata_o, gold[exp_addr[c / 2 - 1]]);
      end
      chk(done_o == (c == 2 * n + 1), {req, " done pulse"}, done_o, c);
      if (c == 2 * n + 1) chk(int'(status_o) == exp_st, {req, " status"}, status_o, exp_st);
      // R11: restart attempt in the middle of the walk
      if (poke && c == 2) begin
        pos_i = 16'(8 * 3 + 1); pat_i = 11'h7ff; len_i = 16'd512; start_i = 1'b1;
      end
    end
    @(negedge clk_i);
    bad = 0;
    for (int a = 0; a < 512; a++) if (mem[a] !== gold[a]) bad++;
    chk(bad == 0, {req, " buffer restored"}, bad, 0);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0 && mem_rd_o == 1'b0 && mem_we_o == 1'b0, "R1 reset idle",
        {done_o, mem_rd_o, mem_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0 && mem_we_o == 1'b0, "R1 after release", {done_o, mem_we_o}, 0);

    run_case("R2 R3 pos1 shift0", 1, 'h5a3, 512, 1, 0);
    run_case("R3 R4 shift6 3 bytes", 8 * 100 + 7, 'h7ff, 512, 2, 0);
    run_case("R4 shift7 3 bytes", 8 * 50 + 8, 'h401, 512, 3, 0);
    run_case("R4 shift5 2 bytes", 8 * 20 + 6, 'h6db, 512, 4, 0);
    run_case("R5 last byte", 8 * 511 + 5, 'h3c5, 512, 5, 0);
    run_case("R5 byte 510 shift7", 8 * 510 + 8, 'h7ff, 512, 6, 0);
    run_case("R6 len 42", 8 * 40 + 7, 'h555, 42, 7, 0);
    run_case("R6 len 41", 8 * 40 + 7, 'h2aa, 41, 8, 0);
    run_case("R8 zero pattern", 8 * 9 + 3, 0, 512, 9, 0);
    run_case("R9 pos zero", 0, 'h123, 512, 10, 0);
    run_case("R9 beyond sector", 8 * 512 + 1, 'h123, 4096, 11, 0);
    run_case("R9 beyond len", 8 * 60 + 2, 'h123, 60, 12, 0);
    run_case("R10 R11 busy restart", 8 * 200 + 7, 'h19d, 512, 13, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule